// File: doc/BRIEF.md
# DRAM Rank Boundary Address Decoder

This block sits in front of a two-channel DRAM controller and decides which of eight ranks, four on channel A and four on channel B, owns a physical request address. Software gives every rank an 8-bit upper limit through a small register port. The limits count in 32 MB steps and accumulate across both channels, so channel B's first rank starts where channel A's last rank stops. An empty rank repeats the limit of the rank below it.

For each request the block takes address bits [32:25], finds the first rank whose limit lies above them and, one clock later, reports the channel, the rank number within that channel and a one-hot chip select. An address at or above the final limit is reported as beyond populated memory, and no chip select is driven for it.

Top module: `rank_boundary_decoder`

## Requirements
- R1: After reset every limit register reads 00h. With all limits at zero, every decode reports out-of-range.
- R2: The limit of rank r (0..3) on channel c (0 = A, 1 = B) is read and written at register offset 100h + 80h*c + r. A read returns the addressed value combinationally in the same cycle. An unmapped offset reads 00h, and a write to it changes no limit.
- R3: Limits count in 32 MB units. Only reqAddr[32:25] takes part in the comparison, so the bits below bit 25 never change the result.
- R4: The selected rank is the lowest one, in the order A0, A1, A2, A3, B0, B1, B2, B3, whose limit is strictly greater than reqAddr[32:25]. Channel B ranks therefore continue the address space above channel A.
- R5: A rank whose limit equals the limit of the rank below it is never selected.
- R6: When reqAddr[32:25] is greater than or equal to the B3 limit, rspOutOfRange is 1 and rspChipSel is 00h.
- R7: For an in-range decode, rspChipSel has exactly one bit set, at position 4*rspChannel + rspRank. rspChannel is 0 for A and 1 for B.
- R8: The outputs of a decode appear with rspValid in the cycle after reqValid is high. In a cycle after reqValid is low, rspValid, rspOutOfRange and rspChipSel are all zero.
- R9: A limit written in the same cycle as a decode does not affect that decode. It applies from the next decode onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 12 | Register offset for read and write |
| regWrEn | input | 1 | Write strobe for regWrData at regAddr |
| regWrData | input | 8 | Limit value to write |
| regRdData | output | 8 | Value at regAddr (combinational) |
| reqValid | input | 1 | A decode request is present |
| reqAddr | input | 33 | Physical request address |
| rspValid | output | 1 | Registered decode result is valid |
| rspChannel | output | 1 | Selected channel, 0 = A, 1 = B |
| rspRank | output | 2 | Selected rank within the channel |
| rspChipSel | output | 8 | One-hot chip select, bit 4*channel+rank |
| rspOutOfRange | output | 1 | Address lies beyond the B3 limit |

## Verification
The bench probes addresses just below and exactly on each limit. A design that compared with greater-or-equal, or that looked at the wrong address bits, would pick the neighbouring rank there. It programs one empty rank on channel B and sends an address equal to that limit, where a decoder without strict lowest-match priority would select the empty rank instead of skipping to the next populated one. Addresses on and above the B3 limit must give no chip select, or the design would drive a nonexistent rank. A limit write that lands together with a decode must leave that decode on the old mapping, or the design would be reading the register's next value instead of its current one.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
  localparam int NUM_CH       = 2;
  localparam int RANKS_PER_CH = 4;
  localparam int NUM_RANKS    = NUM_CH * RANKS_PER_CH;
  localparam int RANK_W       = $clog2(RANKS_PER_CH);
  localparam int SEL_W        = $clog2(NUM_RANKS);
  localparam int BND_W        = 8;
  localparam int ADDR_W       = 33;
  localparam int GRAN_LSB     = 25;
  localparam int REG_ADDR_W   = 12;

  typedef struct packed {
    logic [NUM_RANKS-1:0] wrSel;   // one-hot write enable per limit register
    logic [SEL_W-1:0]     rdIdx;   // limit register addressed for read
    logic                 rdHit;   // regAddr maps to a limit register
    logic                 decode;  // a request is to be decoded this cycle
  } ctrlStrobe_t;
endpackage

// File: rtl/rbd_ctrl.sv
module rbd_ctrl
  import rbd_pkg::*;
#(
  parameter logic [REG_ADDR_W-1:0] BASE_CH_A = 12'h100,
  parameter logic [REG_ADDR_W-1:0] BASE_CH_B = 12'h180
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  regWrEn,
  input  logic                  reqValid,
  output ctrlStrobe_t           strobe
);
  logic [NUM_RANKS-1:0] hit;

  // Offset of each limit register, derived from channel base + rank number
  for (genvar r = 0; r < NUM_RANKS; r++) begin : gRankOfs
    localparam logic [REG_ADDR_W-1:0] CH_BASE = (r / RANKS_PER_CH == 0) ? BASE_CH_A : BASE_CH_B;
    localparam logic [REG_ADDR_W-1:0] OFS     = CH_BASE + REG_ADDR_W'(r % RANKS_PER_CH);
    assign hit[r] = (regAddr == OFS);
  end

  always_comb begin
    strobe.rdIdx = '0;
    for (int r = 0; r < NUM_RANKS; r++) begin
      if (hit[r]) strobe.rdIdx = r[SEL_W-1:0];
    end
    strobe.rdHit  = |hit;
    strobe.wrSel  = hit & {NUM_RANKS{regWrEn}};
    strobe.decode = reqValid;
  end

  // R2: at most one limit register is written per cycle
  assert_wr_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.wrSel));

  // R2: no write strobe without a write request
  assert_wr_needs_en_R2: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |-> (strobe.wrSel == '0));
endmodule

// File: rtl/rbd_datapath.sv
module rbd_datapath
  import rbd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [BND_W-1:0]  regWrData,
  output logic [BND_W-1:0]  regRdData,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  output logic              rspChannel,
  output logic [RANK_W-1:0] rspRank,
  output logic [NUM_RANKS-1:0] rspChipSel,
  output logic              rspOutOfRange
);
  logic [BND_W-1:0]     bound [NUM_RANKS];
  logic [BND_W-1:0]     addrHi;
  logic [NUM_RANKS-1:0] above;
  logic [SEL_W-1:0]     selIdx;
  logic                 found;
  logic                 oorNext;
  logic [NUM_RANKS-1:0] csNext;

  assign addrHi = reqAddr[GRAN_LSB +: BND_W];

  // Limit registers and per-rank comparators
  for (genvar r = 0; r < NUM_RANKS; r++) begin : gRank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                bound[r] <= '0;
      else if (strobe.wrSel[r]) bound[r] <= regWrData;
    end
    assign above[r] = (bound[r] > addrHi);
  end

  assign regRdData = strobe.rdHit ? bound[strobe.rdIdx] : '0;

  // Lowest-index rank whose limit is above the address wins
  always_comb begin
    selIdx = '0;
    found  = 1'b0;
    for (int r = 0; r < NUM_RANKS; r++) begin
      if (!found && above[r]) begin
        selIdx = r[SEL_W-1:0];
        found  = 1'b1;
      end
    end
  end

  assign oorNext = (addrHi >= bound[NUM_RANKS-1]);
  assign csNext  = oorNext ? '0 : (NUM_RANKS'(1) << selIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid      <= 1'b0;
      rspChannel    <= 1'b0;
      rspRank       <= '0;
      rspChipSel    <= '0;
      rspOutOfRange <= 1'b0;
    end else begin
      rspValid <= strobe.decode;
      if (strobe.decode) begin
        rspChannel    <= selIdx[SEL_W-1];
        rspRank       <= selIdx[RANK_W-1:0];
        rspChipSel    <= csNext;
        rspOutOfRange <= oorNext;
      end else begin
        rspChipSel    <= '0;
        rspOutOfRange <= 1'b0;
      end
    end
  end

  // R7: chip select never has more than one bit
  assert_cs_onehot_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rspChipSel));

  // R7: an in-range result drives exactly one chip select
  assert_cs_present_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspOutOfRange) |-> ($countones(rspChipSel) == 1));

  // R6: out-of-range drives no chip select
  assert_oor_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    rspOutOfRange |-> (rspChipSel == '0));

  // R8: one cycle from request to result
  assert_latency_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decode |=> rspValid);

  // R8: no result and no chip select without a request
  assert_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.decode |=> (!rspValid && rspChipSel == '0 && !rspOutOfRange));

  // R2: an unselected limit register keeps its value
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrSel[0] |=> $stable(bound[0]));
endmodule

// File: rtl/rank_boundary_decoder.sv
module rank_boundary_decoder
  import rbd_pkg::*;
#(
  parameter logic [REG_ADDR_W-1:0] BASE_CH_A = 12'h100,
  parameter logic [REG_ADDR_W-1:0] BASE_CH_B = 12'h180
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  regWrEn,
  input  logic [BND_W-1:0]      regWrData,
  output logic [BND_W-1:0]      regRdData,
  input  logic                  reqValid,
  input  logic [ADDR_W-1:0]     reqAddr,
  output logic                  rspValid,
  output logic                  rspChannel,
  output logic [RANK_W-1:0]     rspRank,
  output logic [NUM_RANKS-1:0]  rspChipSel,
  output logic                  rspOutOfRange
);
  ctrlStrobe_t strobe;

  rbd_ctrl #(
    .BASE_CH_A (BASE_CH_A),
    .BASE_CH_B (BASE_CH_B)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .reqValid (reqValid),
    .strobe   (strobe)
  );

  rbd_datapath u_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .regWrData     (regWrData),
    .regRdData     (regRdData),
    .reqAddr       (reqAddr),
    .rspValid      (rspValid),
    .rspChannel    (rspChannel),
    .rspRank       (rspRank),
    .rspChipSel    (rspChipSel),
    .rspOutOfRange (rspOutOfRange)
  );
endmodule

// File: tb/rank_boundary_decoder_tb.sv
module rank_boundary_decoder_tb;
  typedef struct packed {
    logic       oor;
    logic       ch;
    logic [1:0] rank;
    logic [7:0] cs;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic        reqValid = 1'b0;
  logic [32:0] reqAddr = '0;
  logic        rspValid;
  logic        rspChannel;
  logic [1:0]  rspRank;
  logic [7:0]  rspChipSel;
  logic        rspOutOfRange;

  int checks = 0;
  int fails  = 0;
  expItem_t expQ[$];
  string    tagQ[$];
  logic [7:0] model [8];

  always #5 clk = ~clk;

  rank_boundary_decoder u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .reqValid(reqValid),
    .reqAddr(reqAddr), .rspValid(rspValid), .rspChannel(rspChannel),
    .rspRank(rspRank), .rspChipSel(rspChipSel), .rspOutOfRange(rspOutOfRange)
  );

  function automatic logic [11:0] ofs(int idx);
    return 12'h100 + 12'(idx / 4) * 12'h80 + 12'(idx % 4);
  endfunction

  // Expected result from the requirements (R4, R5, R6, R7)
  function automatic expItem_t predict(logic [7:0] hi);
    expItem_t e;
    logic done;
    e = '0;
    done = 1'b0;
    if (hi >= model[7]) e.oor = 1'b1;
    else begin
      for (int r = 0; r < 8; r++) begin
        if (!done && model[r] > hi) begin
          e.ch = (r >= 4);
          e.rank = 2'(r % 4);
          e.cs = 8'(1 << r);
          done = 1'b1;
        end
      end
    end
    return e;
  endfunction

  task automatic idle();
    @(posedge clk); #1;
    regWrEn = 1'b0; reqValid = 1'b0;
  endtask

  task automatic regWrite(int idx, logic [7:0] v);
    @(posedge clk); #1;
    regAddr = ofs(idx); regWrData = v; regWrEn = 1'b1; reqValid = 1'b0;
    model[idx] = v;
  endtask

  task automatic checkRead(logic [11:0] a, logic [7:0] exp, string tag);
    @(posedge clk); #1;
    regWrEn = 1'b0; reqValid = 1'b0; regAddr = a;
    #2;
    checks++;
    if (regRdData !== exp) begin
      fails++;
      $display("FAIL %s read %h: got %h expected %h", tag, a, regRdData, exp);
    end
  endtask

  task automatic decode(logic [7:0] hi, logic [24:0] lo, string tag);
    @(posedge clk); #1;
    regWrEn = 1'b0;
    reqAddr = {hi, lo}; reqValid = 1'b1;
    expQ.push_back(predict(hi));
    tagQ.push_back(tag);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (rspValid) begin
        checks++;
        if (expQ.size() == 0) begin
          fails++;
          $display("FAIL R8 unexpected result: cs %h expected no result", rspChipSel);
        end else begin
          expItem_t e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          if (rspOutOfRange !== e.oor || rspChipSel !== e.cs ||
              (!e.oor && (rspChannel !== e.ch || rspRank !== e.rank))) begin
            fails++;
            $display("FAIL %s: got oor=%b ch=%b rank=%0d cs=%h expected oor=%b ch=%b rank=%0d cs=%h",
                     t, rspOutOfRange, rspChannel, rspRank, rspChipSel,
                     e.oor, e.ch, e.rank, e.cs);
          end
        end
      end else if (rspChipSel !== 8'h00 || rspOutOfRange !== 1'b0) begin
        checks++;
        fails++;
        $display("FAIL R8 idle outputs: cs %h oor %b expected 00 0", rspChipSel, rspOutOfRange);
      end
    end
  end

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin : stimulus
    for (int r = 0; r < 8; r++) model[r] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset values and all-zero map
    for (int r = 0; r < 8; r++) checkRead(ofs(r), 8'h00, "R1");
    decode(8'h00, 25'h0, "R1 zero map out-of-range");
    idle();

    // R2: program map, including an empty rank B1
    regWrite(0, 8'h01); regWrite(1, 8'h02); regWrite(2, 8'h04); regWrite(3, 8'h08);
    regWrite(4, 8'h10); regWrite(5, 8'h10); regWrite(6, 8'h20); regWrite(7, 8'h40);
    for (int r = 0; r < 8; r++) checkRead(ofs(r), model[r], "R2");
    @(posedge clk); #1;
    regAddr = 12'h104; regWrData = 8'h55; regWrEn = 1'b1;
    checkRead(12'h104, 8'h00, "R2 unmapped read");
    checkRead(12'h103, 8'h08, "R2 unmapped write ignored");
    checkRead(12'h184, 8'h00, "R2 unmapped read B");

    // R3: granularity and ignored low bits
    decode(8'h00, 25'h0, "R3 bottom of A0");
    decode(8'h00, 25'h1FFFFFF, "R3 top byte of A0");
    decode(8'h01, 25'h0, "R3 first byte of A1");
    idle();
    // R4: ordering across channels
    decode(8'h03, 25'h123, "R4 A2");
    decode(8'h07, 25'h0, "R4 last unit of A3");
    decode(8'h08, 25'h0, "R4 first unit of B0");
    decode(8'h0F, 25'h1FFFFFF, "R4 last unit of B0");
    // R5: empty rank B1 skipped
    decode(8'h10, 25'h0, "R5 empty B1 skipped");
    decode(8'h3F, 25'h1FFFFFF, "R4 last unit of B3");
    // R6: beyond populated memory
    decode(8'h40, 25'h0, "R6 at B3 limit");
    decode(8'hFF, 25'h1FFFFFF, "R6 top of space");
    idle(); idle();

    // R9: write in the same cycle as a decode
    @(posedge clk); #1;
    regAddr = ofs(0); regWrData = 8'h03; regWrEn = 1'b1;
    reqAddr = {8'h02, 25'h0}; reqValid = 1'b1;
    expQ.push_back(predict(8'h02));
    tagQ.push_back("R9 old map on write cycle");
    model[0] = 8'h03;
    decode(8'h02, 25'h0, "R9 new map applies next");
    // R7: lowest rank wins with non-monotonic limits
    regWrite(2, 8'h01);
    decode(8'h02, 25'h0, "R7 lowest index wins");
    idle(); idle(); idle();

    if (expQ.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL R8 %0d results missing, expected 0", expQ.size());
    end
    finishRun();
  end
endmodule